// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block holds the small set of miscellaneous control registers of a workstation I/O controller. Software reaches them over a simple single-cycle register bus that carries a select, a write enable, a byte address, an access size and a 32-bit write lane. Five registers are 8 bits wide: configuration, diagnostic, modem control, auxiliary function and power-down control. There is also a 16-bit LED register and an 8-bit system-control register that is reached with 32-bit accesses only. Read data is combinational and zero-extended. Write data is taken from the low lanes of the bus.

Several registers act on the system as well as store data. A write to the auxiliary function register can fire a one-cycle terminal-count pulse to the floppy controller. The power-down register latches a power-fail status bit, gated by an enable in the configuration register, and drives a level interrupt. Software clears that status by writing a one to it, and it can request a shutdown. The system-control register raises a reset request and leaves behind a status value that survives the block reset, so software can still read it after a software-initiated restart.

Top module: `aux_sysctl`

## Requirements
- R1: Access size on `busSize` is encoded as 0 = one byte, 1 = two bytes, 2 = four bytes (3 is never valid). The five 8-bit registers accept only size 0, the LED register accepts only size 1 and the system-control register accepts only size 2. A write of the wrong size changes nothing, and a read of the wrong size returns 0.
- R2: The address map is: configuration at 0x00, diagnostic at 0x01, modem control at 0x02, auxiliary function at 0x03, power-down control at 0x04. The LED window is 0x08–0x0F and is live only at 0x08. The system-control window is 0x10–0x1F and is live only at 0x10. All other addresses read 0 and ignore writes.
- R3: `irq` is high exactly when power-down bit 5 (fail status) and configuration bit 3 (power-interrupt enable) are both stored as 1. It follows a register or pin update from the next clock edge.
- R4: Each cycle, the block compares `pwrFail` with its value in the previous cycle (taken as 0 after reset). On a change, bit 5 is set to (`pwrFail` AND configuration bit 3), using the configuration value written in that same cycle if there is one. This overrides bit 5 from a power-down write in the same cycle.
- R5: A power-down write keeps only data bits 0 (power off) and 1 (clear) and merges in the current bit 5. If data bit 1 is set, only bit 0 is stored. Bit 1 therefore always reads 0.
- R6: A power-down write with data bit 0 set produces a one-cycle `shutdownReq` pulse in the following cycle.
- R7: A write to the auxiliary function register with data bit 1 set produces a one-cycle `tcPulse` in the following cycle. Bit 1 is stored as 0 and the other bits are stored as written.
- R8: A 4-byte write at 0x10 with data bit 0 set loads the system-control register with 0x02 and produces a one-cycle `resetReq` pulse in the following cycle. Without bit 0 the write changes nothing.
- R9: Asserting `rstN` (active low) clears configuration, modem control, auxiliary function, power-down and all pulse outputs. The diagnostic, LED and system-control registers keep their contents.
- R10: The LED register stores bits 15:0 of a 2-byte write at 0x08 and returns them on a read of 0x08. Reads at 0x0A, 0x0C and 0x0E return 0.
- R11: The diagnostic and modem-control registers store and return all 8 bits as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| busSel | input | 1 | Access in progress this cycle |
| busWrEn | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte address inside the block |
| busSize | input | 2 | Access size code (R1) |
| busWrData | input | 32 | Write data, low lanes used |
| busRdData | output | 32 | Combinational zero-extended read data |
| pwrFail | input | 1 | Power-fail indication from the supply |
| irq | output | 1 | Level power-fail interrupt |
| tcPulse | output | 1 | Floppy terminal-count pulse |
| shutdownReq | output | 1 | Shutdown request pulse |
| resetReq | output | 1 | System reset request pulse |

## Verification
Two updates can land on power-down bit 5 in the same clock edge: a change on the `pwrFail` pin and a software write to the power-down register, which may carry the clear bit. A configuration write may land in the same edge as well and change the enable that gates the pin event. The bench forces these cases directly: it toggles the pin in the same cycle as a clearing write, and in the same cycle as an enable write. The random phase also lets the pin toggle at any time while writes are in flight. A reference model in the bench applies the write first and the pin event second. Its bit-5 value and `irq` are compared with the block's readback and output on every cycle.

// File: rtl/auxctl_pkg.sv
`timescale 1ns/1ps
package auxctl_pkg;
  parameter int ADDR_W = 5;
  parameter int BUS_W  = 32;
  parameter int REG_W  = 8;
  parameter int LED_W  = 16;
  parameter int NUM_BYTE_REGS = 5;

  localparam logic [ADDR_W-1:0] LED_ADDR = 5'h08;
  localparam logic [ADDR_W-1:0] SYS_ADDR = 5'h10;

  localparam int CFG_PWR_EN_BIT = 3;
  localparam int AUX2_OFF_BIT   = 0;
  localparam int AUX2_CLR_BIT   = 1;
  localparam int AUX2_FAIL_BIT  = 5;
  localparam int AUX1_TC_BIT    = 1;
  localparam int SYS_RST_BIT    = 0;
  localparam logic [REG_W-1:0] SYS_STAT_VAL = 8'h02;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_e;

  typedef enum logic [2:0] {
    RD_NONE, RD_CFG, RD_DIAG, RD_MDM, RD_AUX1, RD_AUX2, RD_LED, RD_SYS
  } rdSel_e;

  typedef struct packed {
    logic wrCfg;
    logic wrDiag;
    logic wrMdm;
    logic wrAux1;
    logic wrAux2;
    logic wrLed;
    logic wrSys;
  } regStrb_t;
endpackage

// File: rtl/auxctl_decode.sv
`timescale 1ns/1ps
module auxctl_decode
  import auxctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output regStrb_t          strb,
  output rdSel_e            rdSel
);
  logic [NUM_BYTE_REGS-1:0] byteHit;
  logic ledHit;
  logic sysHit;
  logic byteSizeOk;

  // one comparator per byte-wide register, addresses 0..NUM_BYTE_REGS-1
  for (genvar g = 0; g < NUM_BYTE_REGS; g++) begin : gByteDec
    assign byteHit[g] = busSel && (busAddr == ADDR_W'(g));
  end

  assign byteSizeOk = (busSize == SZ_BYTE);
  assign ledHit = busSel && (busAddr == LED_ADDR) && (busSize == SZ_HALF);
  assign sysHit = busSel && (busAddr == SYS_ADDR) && (busSize == SZ_WORD);

  always_comb begin
    strb = '0;
    if (busWrEn) begin
      strb.wrCfg  = byteHit[0] && byteSizeOk;
      strb.wrDiag = byteHit[1] && byteSizeOk;
      strb.wrMdm  = byteHit[2] && byteSizeOk;
      strb.wrAux1 = byteHit[3] && byteSizeOk;
      strb.wrAux2 = byteHit[4] && byteSizeOk;
      strb.wrLed  = ledHit;
      strb.wrSys  = sysHit;
    end
  end

  always_comb begin
    rdSel = RD_NONE;
    if (byteSizeOk) begin
      if (byteHit[0]) rdSel = RD_CFG;
      if (byteHit[1]) rdSel = RD_DIAG;
      if (byteHit[2]) rdSel = RD_MDM;
      if (byteHit[3]) rdSel = RD_AUX1;
      if (byteHit[4]) rdSel = RD_AUX2;
    end
    if (ledHit) rdSel = RD_LED;
    if (sysHit) rdSel = RD_SYS;
  end

  // R1: a byte register addressed with a wider size must not be written
  a_r1_size_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrEn && (busAddr < ADDR_W'(NUM_BYTE_REGS)) && (busSize != SZ_BYTE))
      |-> (strb == '0));

  // R2: at most one register is written per access
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/auxctl_regs.sv
`timescale 1ns/1ps
module auxctl_regs
  import auxctl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regStrb_t         strb,
  input  rdSel_e           rdSel,
  input  logic [LED_W-1:0] wrData,
  input  logic             pwrFail,
  output logic [BUS_W-1:0] rdData,
  output logic             irq,
  output logic             tcPulse,
  output logic             shutdownReq,
  output logic             resetReq
);
  logic [REG_W-1:0] cfgQ, mdmQ, aux1Q, aux2Q;
  logic [REG_W-1:0] diagQ, sysQ;
  logic [LED_W-1:0] ledQ;
  logic             pfPrevQ;

  logic [REG_W-1:0] cfgNext, aux2Wr, aux2Next;
  logic             pfChange;

  assign pfChange = pwrFail ^ pfPrevQ;
  assign cfgNext  = strb.wrCfg ? wrData[REG_W-1:0] : cfgQ;

  always_comb begin
    aux2Wr = '0;
    aux2Wr[AUX2_OFF_BIT]  = wrData[AUX2_OFF_BIT];
    aux2Wr[AUX2_CLR_BIT]  = wrData[AUX2_CLR_BIT];
    aux2Wr[AUX2_FAIL_BIT] = aux2Q[AUX2_FAIL_BIT];
    if (aux2Wr[AUX2_CLR_BIT]) begin
      aux2Wr = '0;
      aux2Wr[AUX2_OFF_BIT] = wrData[AUX2_OFF_BIT];
    end
    aux2Next = strb.wrAux2 ? aux2Wr : aux2Q;
    // a pin event is applied after the software write
    if (pfChange) aux2Next[AUX2_FAIL_BIT] = pwrFail && cfgNext[CFG_PWR_EN_BIT];
  end

  // registers cleared by the block reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ        <= '0;
      mdmQ        <= '0;
      aux1Q       <= '0;
      aux2Q       <= '0;
      pfPrevQ     <= 1'b0;
      tcPulse     <= 1'b0;
      shutdownReq <= 1'b0;
      resetReq    <= 1'b0;
    end else begin
      cfgQ    <= cfgNext;
      aux2Q   <= aux2Next;
      pfPrevQ <= pwrFail;
      if (strb.wrMdm) mdmQ <= wrData[REG_W-1:0];
      if (strb.wrAux1) begin
        aux1Q <= wrData[REG_W-1:0];
        aux1Q[AUX1_TC_BIT] <= 1'b0;
      end
      tcPulse     <= strb.wrAux1 && wrData[AUX1_TC_BIT];
      shutdownReq <= strb.wrAux2 && wrData[AUX2_OFF_BIT];
      resetReq    <= strb.wrSys && wrData[SYS_RST_BIT];
    end
  end

  // registers that keep their contents across the block reset
  always_ff @(posedge clk) begin
    if (strb.wrDiag) diagQ <= wrData[REG_W-1:0];
    if (strb.wrLed)  ledQ  <= wrData;
    if (strb.wrSys && wrData[SYS_RST_BIT]) sysQ <= SYS_STAT_VAL;
  end

  assign irq = aux2Q[AUX2_FAIL_BIT] & cfgQ[CFG_PWR_EN_BIT];

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_CFG:  rdData[REG_W-1:0] = cfgQ;
      RD_DIAG: rdData[REG_W-1:0] = diagQ;
      RD_MDM:  rdData[REG_W-1:0] = mdmQ;
      RD_AUX1: rdData[REG_W-1:0] = aux1Q;
      RD_AUX2: rdData[REG_W-1:0] = aux2Q;
      RD_LED:  rdData[LED_W-1:0] = ledQ;
      RD_SYS:  rdData[REG_W-1:0] = sysQ;
      default: rdData = '0;
    endcase
  end

  // R7: a terminal-count pulse only follows an auxiliary write carrying bit 1
  a_r7_tc_cause: assert property (@(posedge clk) disable iff (!rstN)
    tcPulse |-> $past(strb.wrAux1 && wrData[AUX1_TC_BIT]));

  // R6: a shutdown pulse is seen together with the stored power-off bit
  a_r6_off_stored: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> aux2Q[AUX2_OFF_BIT]);

  // R8: a reset request leaves the status value in the system register
  a_r8_status_loaded: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (sysQ == SYS_STAT_VAL));

  // R5: a clearing write with no pin event leaves only bit 0
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrAux2 && wrData[AUX2_CLR_BIT] && !pfChange) |=> (aux2Q[REG_W-1:1] == '0));

  // R4: a pin event with the enable off leaves the status clear
  a_r4_gated_set: assert property (@(posedge clk) disable iff (!rstN)
    (pfChange && !cfgNext[CFG_PWR_EN_BIT]) |=> !aux2Q[AUX2_FAIL_BIT]);
endmodule

// File: rtl/aux_sysctl.sv
`timescale 1ns/1ps
module aux_sysctl
  import auxctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  logic              pwrFail,
  output logic              irq,
  output logic              tcPulse,
  output logic              shutdownReq,
  output logic              resetReq
);
  regStrb_t strb;
  rdSel_e   rdSel;
  logic     unusedLanes;

  assign unusedLanes = ^busWrData[BUS_W-1:LED_W];

  auxctl_decode uDecode (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .busSize (busSize),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  auxctl_regs uRegs (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rdSel       (rdSel),
    .wrData      (busWrData[LED_W-1:0]),
    .pwrFail     (pwrFail),
    .rdData      (busRdData),
    .irq         (irq),
    .tcPulse     (tcPulse),
    .shutdownReq (shutdownReq),
    .resetReq    (resetReq)
  );
endmodule

// File: tb/tb_aux_sysctl.sv
`timescale 1ns/1ps
module tb_aux_sysctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrEn = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        pwrFail = 1'b0;
  logic        irq, tcPulse, shutdownReq, resetReq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  logic [7:0]  mCfg, mDiag, mMdm, mAux1, mAux2, mSys;
  logic [15:0] mLed;
  logic        mPfPrev, eTc, eSd, eRr;

  aux_sysctl dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrEn(busWrEn),
    .busAddr(busAddr), .busSize(busSize), .busWrData(busWrData),
    .busRdData(busRdData), .pwrFail(pwrFail), .irq(irq),
    .tcPulse(tcPulse), .shutdownReq(shutdownReq), .resetReq(resetReq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cycles++;

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [4:0] a, input logic [1:0] sz);
    logic [31:0] r;
    r = '0;
    if (sz == 2'd0) begin
      case (a)
        5'h00: r[7:0] = mCfg;
        5'h01: r[7:0] = mDiag;
        5'h02: r[7:0] = mMdm;
        5'h03: r[7:0] = mAux1;
        5'h04: r[7:0] = mAux2;
        default: r = '0;
      endcase
    end else if (sz == 2'd1 && a == 5'h08) r[15:0] = mLed;
    else if (sz == 2'd2 && a == 5'h10) r[7:0] = mSys;
    return r;
  endfunction

  function automatic string tagFor(input logic [4:0] a);
    if (a == 5'h08) return "R10";
    if (a == 5'h10) return "R8";
    if (a == 5'h03) return "R7";
    if (a == 5'h04) return "R5";
    if (a == 5'h01 || a == 5'h02) return "R11";
    if (a == 5'h00) return "R3";
    return "R2";
  endfunction

  task automatic modelReset();
    mCfg = 0; mMdm = 0; mAux1 = 0; mAux2 = 0;
    mPfPrev = 0; eTc = 0; eSd = 0; eRr = 0;
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic cyc(input bit sel, input bit we, input logic [4:0] a,
                     input logic [1:0] sz, input logic [31:0] d, input bit pin);
    logic [7:0] nCfg, nAux2;
    bit pfCh;
    check("R3 irq", {31'b0, irq}, {31'b0, mAux2[5] & mCfg[3]});
    check("R7 tcPulse", {31'b0, tcPulse}, {31'b0, eTc});
    check("R6 shutdownReq", {31'b0, shutdownReq}, {31'b0, eSd});
    check("R8 resetReq", {31'b0, resetReq}, {31'b0, eRr});
    busSel = sel; busWrEn = we; busAddr = a; busSize = sz; busWrData = d; pwrFail = pin;
    #1;
    if (sel && !we) check({tagFor(a), " read"}, busRdData, modelRead(a, sz));
    // model next state
    eTc = 0; eSd = 0; eRr = 0;
    nCfg = mCfg; nAux2 = mAux2;
    if (sel && we && sz == 2'd0) begin
      case (a)
        5'h00: nCfg = d[7:0];
        5'h01: mDiag = d[7:0];
        5'h02: mMdm = d[7:0];
        5'h03: begin mAux1 = d[7:0] & 8'hFD; eTc = d[1]; end
        5'h04: begin
          nAux2 = {2'b0, mAux2[5], 3'b0, d[1:0]};
          if (d[1]) nAux2 = {7'b0, d[0]};
          eSd = d[0];
        end
        default: ;
      endcase
    end
    if (sel && we && sz == 2'd1 && a == 5'h08) mLed = d[15:0];
    if (sel && we && sz == 2'd2 && a == 5'h10 && d[0]) begin mSys = 8'h02; eRr = 1; end
    pfCh = (pin != mPfPrev);
    if (pfCh) nAux2[5] = pin & nCfg[3];
    mCfg = nCfg; mAux2 = nAux2; mPfPrev = pin;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, input logic [1:0] sz);
    cyc(1, 0, a, sz, $urandom, pwrFail);
  endtask

  task automatic wr(input logic [4:0] a, input logic [1:0] sz, input logic [31:0] d);
    cyc(1, 1, a, sz, d, pwrFail);
  endtask

  task automatic doReset();
    rstN = 0; busSel = 0; pwrFail = 0;
    @(posedge clk); @(negedge clk);
    rstN = 1;
    modelReset();
  endtask

  logic [4:0] addrPool [11] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05,
                                5'h08, 5'h0A, 5'h10, 5'h14, 5'h1C};

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    modelReset();
    @(negedge clk); @(negedge clk);
    doReset();

    // R9: reset state of the cleared registers and outputs
    rd(5'h00, 0); rd(5'h02, 0); rd(5'h03, 0); rd(5'h04, 0);
    check("R9 irq after reset", {31'b0, irq}, 32'h0);

    // give the non-reset registers known values
    wr(5'h01, 0, 32'h0000_00A5);
    wr(5'h08, 1, 32'h0000_1234);
    wr(5'h10, 2, 32'h0000_0001);   // R8: reset request, status 0x02
    rd(5'h10, 2);
    wr(5'h10, 2, 32'h0000_00FE);   // R8: bit 0 clear, no change
    rd(5'h10, 2);
    wr(5'h14, 2, 32'h0000_0001);   // R8: other offset ignored
    rd(5'h14, 2);
    wr(5'h10, 0, 32'h0000_0001);   // R1: wrong size ignored
    rd(5'h10, 0);                  // R1: wrong size read is 0
    rd(5'h01, 1);                  // R1
    wr(5'h08, 2, 32'h0000_FFFF);   // R1
    rd(5'h08, 1);                  // R10
    rd(5'h0A, 1);                  // R10: other offset reads 0

    // R7: terminal-count bit never stored
    wr(5'h03, 0, 32'h0000_00FF); rd(5'h03, 0);
    wr(5'h03, 0, 32'h0000_0040); rd(5'h03, 0);

    // R3/R4: enable then pin rises
    wr(5'h00, 0, 32'h0000_0008);
    cyc(0, 0, 0, 0, 0, 1);
    rd(5'h04, 0);
    // R5: clear with pin steady
    wr(5'h04, 0, 32'h0000_0002); rd(5'h04, 0);
    // R4: pin falls and rises in the same cycle as a clearing write
    cyc(0, 0, 0, 0, 0, 0);
    cyc(1, 1, 5'h04, 0, 32'h0000_0002, 1); rd(5'h04, 0);
    // R4: enable dropped in the same cycle as a pin change
    cyc(1, 1, 5'h00, 0, 32'h0000_0000, 0); rd(5'h04, 0);
    cyc(1, 1, 5'h00, 0, 32'h0000_0008, 1); rd(5'h04, 0);
    // R6: power-off request
    wr(5'h04, 0, 32'h0000_00FD); rd(5'h04, 0);
    wr(5'h04, 0, 32'h0000_0003); rd(5'h04, 0);

    // R9: mid-run reset keeps diagnostic, LED and system-control
    wr(5'h02, 0, 32'h0000_005A);
    doReset();
    rd(5'h01, 0); rd(5'h08, 1); rd(5'h10, 2); rd(5'h02, 0); rd(5'h00, 0);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] a;
      logic [1:0] sz;
      logic [31:0] d;
      bit pin;
      a = addrPool[$urandom_range(10, 0)];
      if ($urandom_range(9, 0) < 8) sz = (a >= 5'h10) ? 2'd2 : ((a >= 5'h08) ? 2'd1 : 2'd0);
      else sz = 2'($urandom_range(3, 0));
      d = $urandom;
      if (d[4]) d[1] = 1'b0;
      pin = ($urandom_range(9, 0) == 0) ? ~pwrFail : pwrFail;
      cyc($urandom_range(3, 0) != 0, $urandom_range(1, 0) != 0, a, sz, d, pin);
    end
    cyc(0, 0, 0, 0, 0, pwrFail);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule